// File: doc/BRIEF.md
# Bus Port Width Adapter

This block sits between a master with a 16-bit data path and an external bus that may hold both 8-bit and 16-bit devices. Address decoding happens elsewhere. For each access, the decoder tells the adapter two things: whether the selected region is byte-wide, and whether the target is an on-chip peripheral register. Wait-state timing also happens elsewhere. The external side reports the end of every bus cycle with a done strobe and may report a bus error.

A word access to a byte-wide region becomes two back-to-back bus cycles. Both cycles use only the upper data lane. The adapter drives the low address bit itself: it is clear for the high byte and set for the low byte. Read bytes are joined into one word, and the master sees a single acknowledge. Accesses to 16-bit regions and to on-chip peripheral registers always complete in a single full-width cycle.

Top module: `bus_port_sizer`

## Requirements
- R1: A word access (m_be = 2'b11) to a byte-wide region (narrow = 1, periph = 0) produces exactly two bus cycles. The master receives exactly one acknowledge, and only after the second cycle's b_done.
- R2: Every bus cycle to a byte-wide region asserts only the upper lane strobe (b_lanes = 2'b10, where bit 1 is D15..D8 and bit 0 is D7..D0). Write data for such a cycle is carried on b_wdata[15:8].
- R3: In a split word access, the first cycle has b_a0 = 0 and carries m_wdata[15:8]. The second cycle has b_a0 = 1 and carries m_wdata[7:0] on the upper lane.
- R4: An access to a 16-bit region (narrow = 0) is one bus cycle with b_lanes = m_be, b_a0 = 0, b_wdata = m_wdata, and m_rdata = b_rdata.
- R5: A split word read returns {first-cycle b_rdata[15:8], second-cycle b_rdata[15:8]}. Bus bits 7..0 have no effect on the result.
- R6: When periph = 1, an access is one full-width cycle (as in R4), whatever the value of narrow.
- R7: A byte access to a byte-wide region is one cycle. With m_be = 2'b10 it uses b_a0 = 0 and carries m_wdata[15:8]. With m_be = 2'b01 it uses b_a0 = 1 and carries m_wdata[7:0] on the upper lane. A read returns the byte in the requested lane of m_rdata, and the other lane is zero.
- R8: If b_err is high with b_done in the first cycle of a split access, no second cycle starts. The master gets m_err for one cycle and no m_ack.
- R9: After reset, b_cyc, m_ack and m_err are low. m_ack or m_err pulses for one cycle, in the cycle after the final b_done.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; released synchronously inside |
| m_req | input | 1 | Master request; held with its qualifiers until acknowledge or error |
| m_write | input | 1 | 1 = write, 0 = read |
| m_be | input | 2 | Byte enables: bit 1 = high byte, bit 0 = low byte |
| m_wdata | input | 16 | Master write data |
| narrow | input | 1 | Selected region is byte-wide |
| periph | input | 1 | Access targets an on-chip peripheral register |
| m_rdata | output | 16 | Read data returned to the master |
| m_ack | output | 1 | One-cycle completion pulse |
| m_err | output | 1 | One-cycle error completion pulse |
| b_cyc | output | 1 | Bus cycle in progress |
| b_write | output | 1 | Bus cycle direction |
| b_a0 | output | 1 | Low address bit for the bus cycle |
| b_lanes | output | 2 | Lane strobes: bit 1 = upper, bit 0 = lower |
| b_wdata | output | 16 | Bus write data |
| b_rdata | input | 16 | Bus read data, sampled with b_done |
| b_done | input | 1 | Current bus cycle ends this clock |
| b_err | input | 1 | Bus error, qualified by b_done |

## Verification
A corrupt sequencing state shows up at the bus pins on the next bus-cycle end. Possible signs are a missing or extra second cycle, b_a0 not stepping, or the wrong byte on the upper lane. The bench's cycle-by-cycle model catches each of these at that b_done. A wrong held byte or a wrong lane merge shows up only in m_rdata at the acknowledge, one cycle after the last b_done. A lost error flag turns m_err into m_ack in that same cycle.

// File: rtl/sz_pkg.sv
package sz_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_FIRST  = 2'd1,
    ST_SECOND = 2'd2,
    ST_RESP   = 2'd3
  } sz_state_e;
endpackage

// File: rtl/sz_rst_sync.sv
module sz_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/sz_ctrl.sv
module sz_ctrl
  import sz_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      m_req,
  input  logic      split,
  input  logic      b_done,
  input  logic      b_err,
  output sz_state_e state,
  output logic      err_q,
  output logic      cap_first,
  output logic      cap_final
);
  sz_state_e state_d;
  logic      err_d;
  logic      on_bus;

  assign on_bus    = (state == ST_FIRST) || (state == ST_SECOND);
  assign cap_first = (state == ST_FIRST) && b_done && !b_err && split;
  assign cap_final = b_done && !b_err &&
                     (((state == ST_FIRST) && !split) || (state == ST_SECOND));

  always_comb begin
    state_d = state;
    unique case (state)
      ST_IDLE:   if (m_req) state_d = ST_FIRST;
      ST_FIRST:  if (b_done) state_d = (split && !b_err) ? ST_SECOND : ST_RESP;
      ST_SECOND: if (b_done) state_d = ST_RESP;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    err_d = err_q;
    if (state == ST_IDLE)           err_d = 1'b0;
    else if (on_bus && b_done && b_err) err_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      err_q <= 1'b0;
    end else begin
      state <= state_d;
      err_q <= err_d;
    end
  end
endmodule

// File: rtl/sz_steer.sv
module sz_steer
  import sz_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  sz_state_e         state,
  input  logic              narrow_eff,
  input  logic              split,
  input  logic              m_write,
  input  logic [1:0]        m_be,
  input  logic [DATA_W-1:0] m_wdata,
  output logic              b_cyc,
  output logic              b_write,
  output logic              b_a0,
  output logic [1:0]        b_lanes,
  output logic [DATA_W-1:0] b_wdata
);
  localparam int BYTE_W = DATA_W / 2;

  logic              pick_low;
  logic [BYTE_W-1:0] lane_byte;

  assign b_cyc   = (state == ST_FIRST) || (state == ST_SECOND);
  assign b_write = m_write;

  always_comb begin
    if (split) pick_low = (state == ST_SECOND);
    else       pick_low = (m_be == 2'b01);
  end

  assign lane_byte = pick_low ? m_wdata[BYTE_W-1:0] : m_wdata[DATA_W-1:BYTE_W];

  always_comb begin
    if (narrow_eff) begin
      b_a0    = pick_low;
      b_lanes = 2'b10;
      b_wdata = {lane_byte, lane_byte};
    end else begin
      b_a0    = 1'b0;
      b_lanes = m_be;
      b_wdata = m_wdata;
    end
  end
endmodule

// File: rtl/sz_asm.sv
module sz_asm #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_first,
  input  logic              cap_final,
  input  logic              narrow_eff,
  input  logic              split,
  input  logic [1:0]        m_be,
  input  logic [DATA_W-1:0] b_rdata,
  output logic [DATA_W-1:0] rdata_q
);
  localparam int BYTE_W = DATA_W / 2;

  logic [BYTE_W-1:0] hi_q, hi_d;
  logic [DATA_W-1:0] rdata_d;
  logic [BYTE_W-1:0] up_byte;

  assign up_byte = b_rdata[DATA_W-1:BYTE_W];

  always_comb begin
    hi_d = hi_q;
    if (cap_first) hi_d = up_byte;
  end

  always_comb begin
    rdata_d = rdata_q;
    if (cap_final) begin
      if (!narrow_eff)         rdata_d = b_rdata;
      else if (split)          rdata_d = {hi_q, up_byte};
      else if (m_be == 2'b01)  rdata_d = {{BYTE_W{1'b0}}, up_byte};
      else                     rdata_d = {up_byte, {BYTE_W{1'b0}}};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q    <= '0;
      rdata_q <= '0;
    end else begin
      hi_q    <= hi_d;
      rdata_q <= rdata_d;
    end
  end
endmodule

// File: rtl/bus_port_sizer.sv
module bus_port_sizer
  import sz_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              m_req,
  input  logic              m_write,
  input  logic [1:0]        m_be,
  input  logic [DATA_W-1:0] m_wdata,
  input  logic              narrow,
  input  logic              periph,
  output logic [DATA_W-1:0] m_rdata,
  output logic              m_ack,
  output logic              m_err,
  output logic              b_cyc,
  output logic              b_write,
  output logic              b_a0,
  output logic [1:0]        b_lanes,
  output logic [DATA_W-1:0] b_wdata,
  input  logic [DATA_W-1:0] b_rdata,
  input  logic              b_done,
  input  logic              b_err
);
  logic      rst_n_i;
  sz_state_e state;
  logic      err_q, cap_first, cap_final;
  logic      narrow_eff, split;

  assign narrow_eff = narrow && !periph;
  assign split      = narrow_eff && (m_be == 2'b11);

  sz_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_i)
  );

  sz_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n_i), .m_req(m_req), .split(split),
    .b_done(b_done), .b_err(b_err), .state(state), .err_q(err_q),
    .cap_first(cap_first), .cap_final(cap_final)
  );

  sz_steer #(.DATA_W(DATA_W)) u_steer (
    .state(state), .narrow_eff(narrow_eff), .split(split),
    .m_write(m_write), .m_be(m_be), .m_wdata(m_wdata),
    .b_cyc(b_cyc), .b_write(b_write), .b_a0(b_a0),
    .b_lanes(b_lanes), .b_wdata(b_wdata)
  );

  sz_asm #(.DATA_W(DATA_W)) u_asm (
    .clk(clk), .rst_n(rst_n_i), .cap_first(cap_first),
    .cap_final(cap_final), .narrow_eff(narrow_eff), .split(split),
    .m_be(m_be), .b_rdata(b_rdata), .rdata_q(m_rdata)
  );

  assign m_ack = (state == ST_RESP) && !err_q;
  assign m_err = (state == ST_RESP) && err_q;
endmodule

// File: rtl/sz_checker.sv
module sz_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       narrow,
  input logic       periph,
  input logic [1:0] m_be,
  input logic       m_ack,
  input logic       m_err,
  input logic       b_cyc,
  input logic       b_a0,
  input logic [1:0] b_lanes,
  input logic       b_done,
  input logic       b_err
);
  AST_NARROW_UPPER_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    b_cyc && narrow && !periph |-> b_lanes == 2'b10); // R2

  AST_A0_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
    b_cyc && b_done && !b_err && !b_a0 && narrow && !periph && m_be == 2'b11
    |=> b_cyc && b_a0); // R3

  AST_WIDE_A0_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    b_cyc && !(narrow && !periph) |-> !b_a0 && b_lanes == m_be); // R4

  AST_PERIPH_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    b_cyc && periph |-> b_lanes == m_be); // R6

  AST_ERR_CANCELS: assert property (@(posedge clk) disable iff (!rst_n)
    b_cyc && b_done && b_err |=> !b_cyc && m_err && !m_ack); // R8

  AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (m_ack || m_err) |=> !m_ack && !m_err); // R9
endmodule

bind bus_port_sizer sz_checker u_chk (
  .clk(clk), .rst_n(rst_n), .narrow(narrow), .periph(periph), .m_be(m_be),
  .m_ack(m_ack), .m_err(m_err), .b_cyc(b_cyc), .b_a0(b_a0),
  .b_lanes(b_lanes), .b_done(b_done), .b_err(b_err)
);

// File: tb/bus_port_sizer_test.sv
`timescale 1ns/1ps
module bus_port_sizer_test;
  logic        clk, rst_n;
  logic        m_req, m_write, narrow, periph;
  logic [1:0]  m_be;
  logic [15:0] m_wdata, m_rdata;
  logic        m_ack, m_err;
  logic        b_cyc, b_write, b_a0;
  logic [1:0]  b_lanes;
  logic [15:0] b_wdata, b_rdata;
  logic        b_done, b_err;

  int errs = 0;
  int checks = 0;
  int cur_wait = 0;
  int wcnt = 0;

  typedef struct {
    string       tag;
    bit          wr;
    bit          a0;
    logic [1:0]  lanes;
    bit          wide;
    logic [15:0] wd;
    logic [15:0] rd;
    bit          err;
  } cyc_t;
  cyc_t q[$];

  bus_port_sizer uut (
    .clk(clk), .rst_n(rst_n), .m_req(m_req), .m_write(m_write), .m_be(m_be),
    .m_wdata(m_wdata), .narrow(narrow), .periph(periph), .m_rdata(m_rdata),
    .m_ack(m_ack), .m_err(m_err), .b_cyc(b_cyc), .b_write(b_write),
    .b_a0(b_a0), .b_lanes(b_lanes), .b_wdata(b_wdata), .b_rdata(b_rdata),
    .b_done(b_done), .b_err(b_err)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp, string what);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // bus device model: ends each cycle after cur_wait extra clocks
  always @(negedge clk) begin
    if (!b_cyc || b_done) begin
      b_done = 1'b0;
      b_err  = 1'b0;
      wcnt   = 0;
    end else if (wcnt < cur_wait) begin
      wcnt++;
    end else if (q.size() == 0) begin
      check("R1", 32'd1, 32'd0, "unexpected bus cycle");
      b_done = 1'b1;
    end else begin
      check(q[0].tag, {31'd0, b_a0}, {31'd0, q[0].a0}, "b_a0");
      check(q[0].tag, {30'd0, b_lanes}, {30'd0, q[0].lanes}, "b_lanes");
      check(q[0].tag, {31'd0, b_write}, {31'd0, q[0].wr}, "b_write");
      if (q[0].wr) begin
        if (q[0].wide) check(q[0].tag, {16'd0, b_wdata}, {16'd0, q[0].wd}, "b_wdata");
        else           check(q[0].tag, {24'd0, b_wdata[15:8]}, {24'd0, q[0].wd[15:8]}, "b_wdata upper");
      end
      b_rdata = q[0].rd;
      b_err   = q[0].err;
      b_done  = 1'b1;
      void'(q.pop_front());
    end
  end

  task automatic push(string tag, bit wr, bit a0, logic [1:0] ln, bit wide,
                      logic [15:0] wd, logic [15:0] rd, bit er);
    cyc_t c;
    c.tag = tag; c.wr = wr; c.a0 = a0; c.lanes = ln; c.wide = wide;
    c.wd = wd; c.rd = rd; c.err = er;
    q.push_back(c);
  endtask

  // one master transaction; dv = device word seen by the model
  task automatic txn(string tag, bit wr, logic [1:0] be, logic [15:0] wd,
                     bit nar, bit per, int w, bit err1, logic [15:0] dv);
    logic [15:0] exp_rd;
    int guard;
    bit byte_port;
    byte_port = nar && !per;
    cur_wait = w;
    if (byte_port && be == 2'b11) begin
      push(tag, wr, 1'b0, 2'b10, 1'b0, {wd[15:8], 8'h00}, {dv[15:8], 8'hA5}, err1);
      if (!err1) push(tag, wr, 1'b1, 2'b10, 1'b0, {wd[7:0], 8'h00}, {dv[7:0], 8'h5A}, 1'b0);
      exp_rd = dv;
    end else if (byte_port && be == 2'b10) begin
      push(tag, wr, 1'b0, 2'b10, 1'b0, {wd[15:8], 8'h00}, {dv[15:8], 8'hC3}, err1);
      exp_rd = {dv[15:8], 8'h00};
    end else if (byte_port) begin
      push(tag, wr, 1'b1, 2'b10, 1'b0, {wd[7:0], 8'h00}, {dv[7:0], 8'h3C}, err1);
      exp_rd = {8'h00, dv[7:0]};
    end else begin
      push(tag, wr, 1'b0, be, 1'b1, wd, dv, err1);
      exp_rd = dv;
    end
    m_write = wr; m_be = be; m_wdata = wd; narrow = nar; periph = per;
    m_req = 1'b1;
    guard = 0;
    do begin
      @(negedge clk);
      guard++;
    end while (!m_ack && !m_err && guard < 200);
    check(tag, {31'd0, m_err}, {31'd0, err1}, "m_err");
    check(tag, {31'd0, m_ack}, {31'd0, !err1}, "m_ack");
    check(tag, q.size(), 32'd0, "pending bus cycles at completion");
    if (!wr && !err1) check(tag, {16'd0, m_rdata}, {16'd0, exp_rd}, "m_rdata");
    m_req = 1'b0;
    q.delete();
    @(negedge clk);
    check("R9", {30'd0, m_ack, m_err}, 32'd0, "completion not a single pulse");
  endtask

  initial begin
    rst_n = 1'b0; m_req = 1'b0; m_write = 1'b0; m_be = 2'b11;
    m_wdata = '0; narrow = 1'b0; periph = 1'b0;
    b_rdata = '0; b_done = 1'b0; b_err = 1'b0;
    repeat (3) @(negedge clk);
    check("R9", {29'd0, b_cyc, m_ack, m_err}, 32'd0, "reset outputs");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R9", {29'd0, b_cyc, m_ack, m_err}, 32'd0, "idle after reset");

    txn("R3", 1'b1, 2'b11, 16'hBEEF, 1'b1, 1'b0, 0, 1'b0, 16'h0000);
    txn("R1", 1'b1, 2'b11, 16'h1234, 1'b1, 1'b0, 3, 1'b0, 16'h0000);
    txn("R5", 1'b0, 2'b11, 16'h0000, 1'b1, 1'b0, 0, 1'b0, 16'hCAFE);
    txn("R5", 1'b0, 2'b11, 16'h0000, 1'b1, 1'b0, 2, 1'b0, 16'h81F0);
    txn("R4", 1'b1, 2'b11, 16'h55AA, 1'b0, 1'b0, 1, 1'b0, 16'h0000);
    txn("R4", 1'b0, 2'b11, 16'h0000, 1'b0, 1'b0, 0, 1'b0, 16'h9ABC);
    txn("R4", 1'b1, 2'b10, 16'h7E01, 1'b0, 1'b0, 0, 1'b0, 16'h0000);
    txn("R4", 1'b0, 2'b01, 16'h0000, 1'b0, 1'b0, 1, 1'b0, 16'h4321);
    txn("R7", 1'b1, 2'b10, 16'hA1B2, 1'b1, 1'b0, 0, 1'b0, 16'h0000);
    txn("R7", 1'b1, 2'b01, 16'hA1B2, 1'b1, 1'b0, 1, 1'b0, 16'h0000);
    txn("R7", 1'b0, 2'b10, 16'h0000, 1'b1, 1'b0, 0, 1'b0, 16'hD00D);
    txn("R7", 1'b0, 2'b01, 16'h0000, 1'b1, 1'b0, 2, 1'b0, 16'hD17E);
    txn("R6", 1'b1, 2'b11, 16'h6006, 1'b1, 1'b1, 0, 1'b0, 16'h0000);
    txn("R6", 1'b0, 2'b11, 16'h0000, 1'b1, 1'b1, 1, 1'b0, 16'h7F80);
    txn("R6", 1'b0, 2'b01, 16'h0000, 1'b1, 1'b1, 0, 1'b0, 16'h1357);
    txn("R8", 1'b0, 2'b11, 16'h0000, 1'b1, 1'b0, 0, 1'b1, 16'hFFFF);
    txn("R8", 1'b1, 2'b11, 16'h2468, 1'b1, 1'b0, 2, 1'b1, 16'h0000);
    txn("R5", 1'b0, 2'b11, 16'h0000, 1'b1, 1'b0, 0, 1'b0, 16'h0F0F);
    txn("R8", 1'b0, 2'b11, 16'h0000, 1'b0, 1'b0, 0, 1'b1, 16'h0000);
    txn("R2", 1'b1, 2'b11, 16'hF00D, 1'b1, 1'b0, 1, 1'b0, 16'h0000);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errs++;
    checks++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule